// File: doc/BRIEF.md
# Half-Bridge Gate Drive Control Logic

This block is the digital control core of a synchronous-buck gate driver. It takes inputs that have already been decoded by analog comparators: a PWM level (low, high or mid-window), a tri-level mode input, a supply-good flag and an inductor zero-crossing flag. From these it drives the high-side and low-side gate enables and reports whether the driver is enabled.

A sequencer with five states is at the centre of the block.
- `ST_UVLO` is the supply-low state.
- `ST_START` counts out the startup cycles.
- `ST_RUN` is the only state that allows switching.
- `ST_SLEEP` is the low-power shutdown state, entered while the mode input is high-impedance.
- `ST_WAKE` counts out the restart latency.

The sequencer has these transitions:
- power_good: `ST_UVLO`→`ST_START`.
- start_done: `ST_START`→`ST_RUN`, or `ST_START`→`ST_SLEEP` when the mode input is high-impedance.
- sleep_req: `ST_RUN`→`ST_SLEEP`, and also `ST_WAKE`→`ST_SLEEP`.
- wake_req: `ST_SLEEP`→`ST_WAKE`.
- wake_done: `ST_WAKE`→`ST_RUN`.
- supply_lost: any state→`ST_UVLO`.

Beside the sequencer there are two smaller pieces. A hold-off timer decides when a mid-level PWM input turns both gates off. A zero-crossing guard cuts the low side in diode-emulation mode.

The gate outputs are combinational from the inputs and the registered state. A change of mode, of supply-good or of zero-crossing therefore acts in the same cycle. No PWM edge is needed.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While `vcc_ok` is 0, `gh` and `gl` are 0 in the same cycle, and `drv_en` is 0 from the next cycle on.
- R2: After `vcc_ok` rises, `drv_en` and switching stay off for START_CYC+1 clock edges, counting the edge that first samples `vcc_ok` high. After that, `drv_en`=1 and the outputs follow PWM.
- R3: `pwm_lvl` encoding is 0 low, 1 high, 2 mid, and 3 is treated as mid. `mode_lvl` encoding is 0 diode emulation, 1 forced continuous conduction, 2 high-impedance, and 3 is treated as high-impedance. With mode 1, PWM high gives `gh`=1, `gl`=0, and PWM low gives `gh`=0, `gl`=1, whatever `zc_neg` is.
- R4: When PWM is mid, the outputs keep the last low or high level. Once HOLD_CYC consecutive edges have sampled PWM mid, `gh` and `gl` are both 0.
- R5: A low or high PWM sample before the hold-off expires makes the outputs follow that level at once, and it restarts the hold-off count from zero.
- R6: With mode 0 and PWM low, `gl`=1 while `zc_neg`=0. `gl` drops to 0 in the same cycle that `zc_neg` is 1, and it stays 0 after `zc_neg` falls. With mode 0 and PWM high, `gh`=1 and `gl`=0.
- R7: The zero-crossing block clears at the first edge that samples PWM high, so `gl` can conduct again on the next low phase.
- R8: With mode 2 or 3, `gh` and `gl` are 0 in the same cycle whatever the PWM level, and `drv_en` is 0 from the next cycle on.
- R9: After the mode input leaves high-impedance, switching resumes only after WAKE_CYC+1 clock edges, counting the edge that samples the new mode.
- R10: A mode change between continuous conduction and diode emulation takes effect on the outputs in the same cycle, with no PWM edge.
- R11: `gh` and `gl` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_ok | input | 1 | Supply above the undervoltage threshold |
| pwm_lvl | input | 2 | Decoded PWM level (0 low, 1 high, 2/3 mid) |
| mode_lvl | input | 2 | Decoded mode (0 diode emulation, 1 forced CCM, 2/3 high-impedance) |
| zc_neg | input | 1 | Inductor current has crossed zero toward negative |
| gh | output | 1 | High-side gate enable |
| gl | output | 1 | Low-side gate enable |
| drv_en | output | 1 | Driver enabled (sequencer in run state) |

## Verification
The assertions check, on every cycle, the properties that hold for any input pattern:
- The two gates never overlap.
- Supply loss and high-impedance mode silence both gates in the same cycle and clear `drv_en` on the next.
- A zero crossing in diode emulation blocks the low side.
- The high side conducts only while the driver is enabled.

Some behaviour depends on counted windows and on history, and only the bench scenarios can show it. This covers the exact startup and wake latencies, the hold-off expiry and its restart on an early exit, the persistence of the zero-crossing block and its clearing on PWM high, and the same-cycle effect of a mode change.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

    typedef enum logic [1:0] {
        PWM_LO  = 2'd0,
        PWM_HI  = 2'd1,
        PWM_MID = 2'd2,
        PWM_RSV = 2'd3
    } pwm_lvl_e;

    typedef enum logic [1:0] {
        MODE_DE  = 2'd0,
        MODE_CCM = 2'd1,
        MODE_HIZ = 2'd2,
        MODE_RSV = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_UVLO  = 3'd0,
        ST_START = 3'd1,
        ST_RUN   = 3'd2,
        ST_SLEEP = 3'd3,
        ST_WAKE  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/hb_startup_seq.sv
module hb_startup_seq
    import hb_gate_pkg::*;
#(
    parameter int START_CYC = 8,
    parameter int WAKE_CYC  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic hiz,
    output logic run
);

    localparam int MAX_CYC = (START_CYC > WAKE_CYC) ? START_CYC : WAKE_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] START_LAST = CW'(START_CYC - 1);
    localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYC - 1);

    seq_state_e     st_q;
    seq_state_e     st_d;
    logic [CW-1:0]  cnt_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_UVLO: begin
                if (vcc_ok) st_d = ST_START;                 // power_good
            end
            ST_START: begin
                if (cnt_q == START_LAST)                     // start_done
                    st_d = hiz ? ST_SLEEP : ST_RUN;
            end
            ST_RUN: begin
                if (hiz) st_d = ST_SLEEP;                    // sleep_req
            end
            ST_SLEEP: begin
                if (!hiz) st_d = ST_WAKE;                    // wake_req
            end
            ST_WAKE: begin
                if (hiz) st_d = ST_SLEEP;                    // sleep_req
                else if (cnt_q == WAKE_LAST) st_d = ST_RUN;  // wake_done
            end
            default: st_d = ST_UVLO;
        endcase
        if (!vcc_ok) st_d = ST_UVLO;                         // supply_lost
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_UVLO;
        end else begin
            st_q <= st_d;
        end
    end

    // latency counter, restarted on every state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (st_d != st_q) begin
            cnt_q <= '0;
        end else if (st_q == ST_START || st_q == ST_WAKE) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // output
    always_comb begin
        run = (st_q == ST_RUN);
    end

endmodule

// File: rtl/hb_holdoff.sv
module hb_holdoff
    import hb_gate_pkg::*;
#(
    parameter int HOLD_CYC = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_lvl,
    output logic [1:0] eff_lvl
);

    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_END = HW'(HOLD_CYC);

    logic          mid;
    logic [HW-1:0] hold_q;
    logic [1:0]    last_q;
    logic          expired;

    always_comb begin
        mid     = pwm_lvl[1];
        expired = (hold_q == HOLD_END);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            last_q <= PWM_MID;
        end else if (!mid) begin
            hold_q <= '0;
            last_q <= pwm_lvl;
        end else if (!expired) begin
            hold_q <= hold_q + 1'b1;
        end
    end

    always_comb begin
        if (!mid) begin
            eff_lvl = pwm_lvl;
        end else if (expired) begin
            eff_lvl = PWM_MID;
        end else begin
            eff_lvl = last_q;
        end
    end

endmodule

// File: rtl/hb_zc_guard.sv
module hb_zc_guard
    import hb_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       de_mode,
    input  logic       run,
    input  logic [1:0] pwm_lvl,
    input  logic [1:0] eff_lvl,
    input  logic       zc_neg,
    output logic       gl_block
);

    logic blk_q;
    logic set_blk;
    logic clr_blk;

    always_comb begin
        set_blk  = run && de_mode && (eff_lvl == PWM_LO) && zc_neg;
        clr_blk  = (pwm_lvl == PWM_HI) || !de_mode;
        gl_block = blk_q || zc_neg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q <= 1'b0;
        end else if (clr_blk) begin
            blk_q <= 1'b0;
        end else if (set_blk) begin
            blk_q <= 1'b1;
        end
    end

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_gate_pkg::*;
#(
    parameter int START_CYC = 8,
    parameter int HOLD_CYC  = 6,
    parameter int WAKE_CYC  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_ok,
    input  logic [1:0] pwm_lvl,
    input  logic [1:0] mode_lvl,
    input  logic       zc_neg,
    output logic       gh,
    output logic       gl,
    output logic       drv_en
);

    logic       run;
    logic       hiz;
    logic       de_mode;
    logic       ccm;
    logic [1:0] eff_lvl;
    logic       gl_block;

    always_comb begin
        hiz     = mode_lvl[1];
        de_mode = (mode_lvl == MODE_DE);
        ccm     = (mode_lvl == MODE_CCM);
    end

    hb_startup_seq #(
        .START_CYC (START_CYC),
        .WAKE_CYC  (WAKE_CYC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .vcc_ok (vcc_ok),
        .hiz    (hiz),
        .run    (run)
    );

    hb_holdoff #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwm_lvl (pwm_lvl),
        .eff_lvl (eff_lvl)
    );

    hb_zc_guard u_zc (
        .clk      (clk),
        .rst_n    (rst_n),
        .de_mode  (de_mode),
        .run      (run),
        .pwm_lvl  (pwm_lvl),
        .eff_lvl  (eff_lvl),
        .zc_neg   (zc_neg),
        .gl_block (gl_block)
    );

    // gate outputs
    always_comb begin
        gh     = 1'b0;
        gl     = 1'b0;
        drv_en = run;
        if (run && vcc_ok && !hiz) begin
            unique case (eff_lvl)
                PWM_HI:  gh = 1'b1;
                PWM_LO:  gl = ccm ? 1'b1 : !gl_block;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vcc_ok,
    input logic [1:0] pwm_lvl,
    input logic [1:0] mode_lvl,
    input logic       zc_neg,
    input logic       gh,
    input logic       gl,
    input logic       drv_en
);

    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(gh && gl));

    a_r1_uvlo_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |-> (!gh && !gl));

    a_r1_uvlo_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok |=> !drv_en);

    a_r2_en_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> $past(vcc_ok));

    a_r8_hiz_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        mode_lvl[1] |-> (!gh && !gl));

    a_r8_hiz_disable: assert property (@(posedge clk) disable iff (!rst_n)
        mode_lvl[1] |=> !drv_en);

    a_r6_zc_cuts_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_lvl == 2'd0 && zc_neg) |-> !gl);

    a_r3_high_needs_pwm: assert property (@(posedge clk) disable iff (!rst_n)
        gh |-> (drv_en && pwm_lvl != 2'd0));

endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vcc_ok   (vcc_ok),
    .pwm_lvl  (pwm_lvl),
    .mode_lvl (mode_lvl),
    .zc_neg   (zc_neg),
    .gh       (gh),
    .gl       (gl),
    .drv_en   (drv_en)
);

// File: tb/hb_gate_ctrl_test.sv
`timescale 1ns/1ps
module hb_gate_ctrl_test;

    localparam int START_CYC = 8;
    localparam int HOLD_CYC  = 6;
    localparam int WAKE_CYC  = 20;
    localparam int NVEC      = 9;

    localparam logic [1:0] P_LO = 2'd0, P_HI = 2'd1, P_MID = 2'd2;
    localparam logic [1:0] M_DE = 2'd0, M_CCM = 2'd1, M_HIZ = 2'd2;

    // {pwm[1:0], mode[1:0], zc, exp_gh, exp_gl}
    localparam logic [6:0] VEC [0:NVEC-1] = '{
        {P_HI, M_CCM, 1'b0, 1'b1, 1'b0},  // R3
        {P_LO, M_CCM, 1'b0, 1'b0, 1'b1},  // R3
        {P_LO, M_CCM, 1'b1, 1'b0, 1'b1},  // R3 negative current allowed
        {P_HI, M_DE,  1'b0, 1'b1, 1'b0},  // R6
        {P_LO, M_DE,  1'b0, 1'b0, 1'b1},  // R6
        {P_LO, M_DE,  1'b1, 1'b0, 1'b0},  // R6 cut
        {P_HI, M_DE,  1'b0, 1'b1, 1'b0},  // R7 clears block
        {P_LO, M_DE,  1'b0, 1'b0, 1'b1},  // R7 conducts again
        {P_HI, M_CCM, 1'b0, 1'b1, 1'b0}   // R3
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       vcc_ok;
    logic [1:0] pwm_lvl;
    logic [1:0] mode_lvl;
    logic       zc_neg;
    logic       gh;
    logic       gl;
    logic       drv_en;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    hb_gate_ctrl #(
        .START_CYC (START_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .WAKE_CYC  (WAKE_CYC)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .vcc_ok   (vcc_ok),
        .pwm_lvl  (pwm_lvl),
        .mode_lvl (mode_lvl),
        .zc_neg   (zc_neg),
        .gh       (gh),
        .gl       (gl),
        .drv_en   (drv_en)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_gates(input string tag, input logic egh, input logic egl);
        n_chk++;
        if (gh !== egh || gl !== egl) begin
            n_fail++;
            $display("FAIL %s: gh/gl = %b%b, expected %b%b", tag, gh, gl, egh, egl);
        end
    endtask

    task automatic chk_en(input string tag, input logic een);
        n_chk++;
        if (drv_en !== een) begin
            n_fail++;
            $display("FAIL %s: drv_en = %b, expected %b", tag, drv_en, een);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        vcc_ok   = 1'b0;
        pwm_lvl  = P_MID;
        mode_lvl = M_CCM;
        zc_neg   = 1'b0;
        tick(3);
        chk_gates("R1 reset", 1'b0, 1'b0);
        chk_en("R1 reset", 1'b0);

        rst_n   = 1'b1;
        pwm_lvl = P_HI;
        tick(4);
        chk_gates("R1 supply low", 1'b0, 1'b0);
        chk_en("R1 supply low", 1'b0);

        // startup latency
        vcc_ok = 1'b1;
        tick(START_CYC);
        chk_en("R2 still starting", 1'b0);
        chk_gates("R2 still starting", 1'b0, 1'b0);
        tick(1);
        chk_en("R2 started", 1'b1);
        chk_gates("R2 started", 1'b1, 1'b0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            pwm_lvl  = VEC[i][6:5];
            mode_lvl = VEC[i][4:3];
            zc_neg   = VEC[i][2];
            #1;
            chk_gates($sformatf("R3 R6 R7 vector %0d", i), VEC[i][1], VEC[i][0]);
            n_chk++;
            if (gh && gl) begin
                n_fail++;
                $display("FAIL R11 vector %0d: gh/gl = 11, expected not both", i);
            end
            tick(1);
        end

        // R6 block persists after zc falls
        mode_lvl = M_DE; pwm_lvl = P_LO; zc_neg = 1'b1;
        #1;
        chk_gates("R6 immediate cut", 1'b0, 1'b0);
        tick(1);
        zc_neg = 1'b0;
        #1;
        chk_gates("R6 latched", 1'b0, 1'b0);
        tick(2);
        chk_gates("R6 still latched", 1'b0, 1'b0);

        // R10 mode change acts in the same cycle
        mode_lvl = M_CCM;
        #1;
        chk_gates("R10 to CCM", 1'b0, 1'b1);
        tick(1);
        mode_lvl = M_DE;
        #1;
        chk_gates("R10 back to DE", 1'b0, 1'b1);
        pwm_lvl = P_HI;
        #1;
        chk_gates("R10 DE high", 1'b1, 1'b0);
        tick(1);

        // R7 clear on PWM high
        pwm_lvl = P_LO; zc_neg = 1'b1;
        tick(1);
        zc_neg = 1'b0;
        #1;
        chk_gates("R7 blocked", 1'b0, 1'b0);
        pwm_lvl = P_HI;
        #1;
        chk_gates("R7 high", 1'b1, 1'b0);
        tick(1);
        pwm_lvl = P_LO;
        #1;
        chk_gates("R7 conducts again", 1'b0, 1'b1);

        // R4 hold-off
        mode_lvl = M_CCM; pwm_lvl = P_HI;
        tick(1);
        pwm_lvl = P_MID;
        #1;
        chk_gates("R4 hold entry", 1'b1, 1'b0);
        tick(HOLD_CYC - 1);
        chk_gates("R4 before expiry", 1'b1, 1'b0);
        tick(1);
        chk_gates("R4 expired", 1'b0, 1'b0);
        mode_lvl = M_DE;
        #1;
        chk_gates("R4 DE mid", 1'b0, 1'b0);

        // R5 early exit and restart
        mode_lvl = M_CCM; pwm_lvl = P_HI;
        tick(1);
        pwm_lvl = P_MID;
        tick(HOLD_CYC - 2);
        chk_gates("R5 holding", 1'b1, 1'b0);
        pwm_lvl = P_LO;
        #1;
        chk_gates("R5 early exit", 1'b0, 1'b1);
        tick(1);
        pwm_lvl = P_MID;
        tick(HOLD_CYC - 1);
        chk_gates("R5 count restarted", 1'b0, 1'b1);
        tick(1);
        chk_gates("R5 expired", 1'b0, 1'b0);

        // R8 high-impedance shutdown, R9 wake latency
        pwm_lvl = P_HI;
        tick(1);
        chk_gates("R8 pre", 1'b1, 1'b0);
        mode_lvl = M_HIZ;
        #1;
        chk_gates("R8 immediate off", 1'b0, 1'b0);
        tick(1);
        chk_en("R8 disabled", 1'b0);
        tick(5);
        chk_gates("R8 stays off", 1'b0, 1'b0);
        mode_lvl = M_CCM;
        tick(WAKE_CYC);
        chk_en("R9 waking", 1'b0);
        chk_gates("R9 waking", 1'b0, 1'b0);
        tick(1);
        chk_en("R9 awake", 1'b1);
        chk_gates("R9 awake", 1'b1, 1'b0);

        // R1 supply loss while running
        vcc_ok = 1'b0;
        #1;
        chk_gates("R1 loss immediate", 1'b0, 1'b0);
        tick(1);
        chk_en("R1 loss disable", 1'b0);
        vcc_ok = 1'b1;
        tick(START_CYC);
        chk_en("R2 restart pending", 1'b0);
        tick(1);
        chk_en("R2 restart done", 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule